// File: doc/BRIEF.md
# Interrupt Security Target Controller

This block holds the per-interrupt state of a small interrupt controller whose interrupts are split between a Secure and a Non-Secure domain. For every external interrupt it keeps an enable bit, a pending bit, a 3-bit priority and a target bit. Target 0 assigns the interrupt to the Secure domain and target 1 assigns it to the Non-Secure domain. Software reaches the state through a request/response register port. Each request carries the requester's security and privilege attributes. Writes that the requester may not make are dropped and flagged on a one-cycle violation strobe. Reads of state that the requester may not see return zero.

A combinational selector looks at every interrupt that is both pending and enabled. It reports the most urgent one: its number, its target domain and its effective priority. It also reports whether that interrupt preempts the current execution priority. A control bit, writable only by privileged Secure code, can push every Non-Secure priority into the lower-urgency half of the range.

The register port is driven by a two-state machine:
- `ST_IDLE`: the port is ready, and an accepted request is latched. Transition *accept* goes to `ST_EXEC`. With no request the state stays in `ST_IDLE` (*wait*).
- `ST_EXEC`: the latched request is decided, and read data, the response and any violation are presented. At the closing edge any permitted write is committed, and transition *finish* returns to `ST_IDLE`.

Top module: `irq_sec_ctrl`

## Requirements
- R1: After reset every interrupt has target 0 (Secure), enable 0, pending 0 and priority 0, and the control bit is 0. With nothing pending and enabled, `sel_valid` is 0.
- R2: The target bit is held in register address 2, bit i for interrupt i: 0 means Secure and 1 means Non-Secure. `sel_target` reports the winning interrupt's target bit.
- R3: A write to address 2 takes effect only when both `req_secure` and `req_priv` are 1. Any other write to it leaves the target bits unchanged and raises `rsp_violation`.
- R4: Enable (address 0) and pending (address 1) are 16-bit vectors, bit i for interrupt i. Priorities sit at addresses 4 to 7: bits 4k+2..4k of address 4+g hold the priority of interrupt 4g+k. A Secure write may change these fields for every interrupt. A Non-Secure write changes them only for interrupts with target 1. For a Non-Secure write, any field of a Secure-target interrupt that the data would alter is kept, and `rsp_violation` is raised.
- R5: A Non-Secure read returns zero in the enable, pending and priority fields of Secure-target interrupts. It also returns zero for the whole of addresses 2 and 3.
- R6: The selector picks, among interrupts that are both pending and enabled, the one with the lowest effective priority value. On a tie the lower interrupt number wins.
- R7: `sel_preempt` is 1 exactly when a winner exists and its effective priority is strictly lower in value than `cur_prio`, whatever the winner's domain. A `cur_prio` of 8 means no active handler.
- R8: While control bit 0 (address 3) is 1, a Non-Secure interrupt with priority p has effective priority 4 + floor(p/2). Secure priorities are unchanged.
- R9: A write to address 3 takes effect only when both `req_secure` and `req_priv` are 1. Any other write to it leaves the control bit unchanged and raises `rsp_violation`.
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the following cycle `rsp_valid` is 1 for exactly one cycle, with the read data and the violation strobe. A write becomes visible from the cycle after that response.
- R11: A 1 on `irq_in[i]` sets pending bit i at the next clock edge, whether or not interrupt i is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 16 | Write data |
| req_secure | input | 1 | Requester is in the Secure state |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 16 | Read data (filtered by requester security) |
| rsp_violation | output | 1 | One-cycle strobe for a refused write |
| irq_in | input | 16 | Interrupt request lines, each sets pending |
| cur_prio | input | 4 | Current execution priority (8 = none active) |
| sel_valid | output | 1 | A pending enabled interrupt exists |
| sel_irq | output | 4 | Number of the winning interrupt |
| sel_target | output | 1 | Target domain of the winner (1 = Non-Secure) |
| sel_prio | output | 3 | Effective priority of the winner |
| sel_preempt | output | 1 | Winner preempts the current execution priority |

## Verification
The hardest situation to reach is a tie between a Secure interrupt and a Non-Secure interrupt that exists only after remapping. The two start with different raw priorities and reach equal effective values only once the control bit is set. The stimulus first programs a Secure interrupt to priority 5 and a Non-Secure one to priority 3, with both pending and enabled, and confirms that the Non-Secure one wins. It then sets the control bit from privileged Secure and expects the Secure interrupt with the lower number to take over. A second hard case is a partially refused Non-Secure write: the stimulus clears a pending vector that mixes both domains, and the bench then reads back which bits survived.

// File: rtl/irq_sec_pkg.sv
package irq_sec_pkg;

    localparam int unsigned DEF_NUM_IRQ = 16;
    localparam int unsigned DEF_PRIO_W  = 3;
    localparam int unsigned DEF_ADDR_W  = 4;
    localparam int unsigned LANE_W      = 4;
    localparam int unsigned PRIO_BASE   = 4;

    localparam logic [3:0] ADR_ENABLE = 4'd0;
    localparam logic [3:0] ADR_PEND   = 4'd1;
    localparam logic [3:0] ADR_TARGET = 4'd2;
    localparam logic [3:0] ADR_CTRL   = 4'd3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } acc_state_e;

endpackage

// File: rtl/irq_sec_access.sv
module irq_sec_access
    import irq_sec_pkg::*;
#(
    parameter int unsigned NUM_IRQ = DEF_NUM_IRQ,
    parameter int unsigned PRIO_W  = DEF_PRIO_W,
    parameter int unsigned ADDR_W  = DEF_ADDR_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [NUM_IRQ-1:0]              req_wdata,
    input  logic                            req_secure,
    input  logic                            req_priv,
    output logic                            rsp_valid,
    output logic [NUM_IRQ-1:0]              rsp_rdata,
    output logic                            rsp_violation,
    input  logic [NUM_IRQ-1:0]              en_q,
    input  logic [NUM_IRQ-1:0]              pend_q,
    input  logic [NUM_IRQ-1:0]              tgt_q,
    input  logic                            ctrl_q,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_q,
    output logic                            en_we,
    output logic [NUM_IRQ-1:0]              en_wd,
    output logic                            pend_we,
    output logic [NUM_IRQ-1:0]              pend_wd,
    output logic                            tgt_we,
    output logic [NUM_IRQ-1:0]              tgt_wd,
    output logic                            ctrl_we,
    output logic                            ctrl_wd,
    output logic                            prio_we,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_wd
);

    localparam int unsigned LANES     = NUM_IRQ / LANE_W;
    localparam int unsigned PRIO_REGS = NUM_IRQ / LANES;

    acc_state_e                state_q, state_d;
    logic                      lat_write, lat_secure, lat_priv;
    logic [ADDR_W-1:0]         lat_addr;
    logic [NUM_IRQ-1:0]        lat_wdata;

    logic                      in_exec, wr, s_priv, viol, is_prio;
    logic [NUM_IRQ-1:0]        own_mask;
    int                        addr_i, grp;
    logic [PRIO_W-1:0]         field;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lat_write  <= 1'b0;
            lat_addr   <= '0;
            lat_wdata  <= '0;
            lat_secure <= 1'b0;
            lat_priv   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                lat_write  <= req_write;
                lat_addr   <= req_addr;
                lat_wdata  <= req_wdata;
                lat_secure <= req_secure;
                lat_priv   <= req_priv;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EXEC : ST_IDLE;
            ST_EXEC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs: decision, filtered write data, filtered read data
    always_comb begin
        in_exec   = (state_q == ST_EXEC);
        wr        = in_exec && lat_write;
        s_priv    = lat_secure && lat_priv;
        own_mask  = lat_secure ? '1 : tgt_q;
        addr_i    = int'(lat_addr);
        is_prio   = (addr_i >= int'(PRIO_BASE)) && (addr_i < int'(PRIO_BASE + PRIO_REGS));
        grp       = addr_i - int'(PRIO_BASE);
        field     = '0;
        viol      = 1'b0;
        rsp_rdata = '0;
        en_we     = 1'b0;
        en_wd     = en_q;
        pend_we   = 1'b0;
        pend_wd   = pend_q;
        tgt_we    = 1'b0;
        tgt_wd    = lat_wdata;
        ctrl_we   = 1'b0;
        ctrl_wd   = lat_wdata[0];
        prio_we   = 1'b0;
        prio_wd   = prio_q;
        if (lat_addr == ADR_ENABLE) begin
            en_we     = wr;
            en_wd     = (lat_wdata & own_mask) | (en_q & ~own_mask);
            viol      = wr && (|((lat_wdata ^ en_q) & ~own_mask));
            rsp_rdata = en_q & own_mask;
        end else if (lat_addr == ADR_PEND) begin
            pend_we   = wr;
            pend_wd   = (lat_wdata & own_mask) | (pend_q & ~own_mask);
            viol      = wr && (|((lat_wdata ^ pend_q) & ~own_mask));
            rsp_rdata = pend_q & own_mask;
        end else if (lat_addr == ADR_TARGET) begin
            tgt_we    = wr && s_priv;
            viol      = wr && !s_priv;
            rsp_rdata = lat_secure ? tgt_q : '0;
        end else if (lat_addr == ADR_CTRL) begin
            ctrl_we      = wr && s_priv;
            viol         = wr && !s_priv;
            rsp_rdata[0] = lat_secure && ctrl_q;
        end else if (is_prio) begin
            prio_we = wr;
            for (int i = 0; i < int'(NUM_IRQ); i++) begin
                if ((i / int'(LANES)) == grp) begin
                    field = lat_wdata[(i % int'(LANES)) * int'(LANE_W) +: PRIO_W];
                    if (own_mask[i]) begin
                        prio_wd[i] = field;
                        rsp_rdata[(i % int'(LANES)) * int'(LANE_W) +: PRIO_W] = prio_q[i];
                    end else if (wr && field != prio_q[i]) begin
                        viol = 1'b1;
                    end
                end
            end
        end
        req_ready     = (state_q == ST_IDLE);
        rsp_valid     = in_exec;
        rsp_violation = in_exec && viol;
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R10
    AST_VIOL_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n) rsp_violation |-> rsp_valid); // R10
    AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> rsp_valid); // R10
    AST_NS_KEEPS_SEC_EN: assert property (@(posedge clk) disable iff (!rst_n) $past(en_we && !lat_secure) |-> (((en_q ^ $past(en_q)) & ~$past(tgt_q)) == '0)); // R4

endmodule

// File: rtl/irq_sec_bank.sv
module irq_sec_bank
    import irq_sec_pkg::*;
#(
    parameter int unsigned NUM_IRQ = DEF_NUM_IRQ,
    parameter int unsigned PRIO_W  = DEF_PRIO_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_IRQ-1:0]              irq_in,
    input  logic                            en_we,
    input  logic [NUM_IRQ-1:0]              en_wd,
    input  logic                            pend_we,
    input  logic [NUM_IRQ-1:0]              pend_wd,
    input  logic                            tgt_we,
    input  logic [NUM_IRQ-1:0]              tgt_wd,
    input  logic                            ctrl_we,
    input  logic                            ctrl_wd,
    input  logic                            prio_we,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_wd,
    output logic [NUM_IRQ-1:0]              en_q,
    output logic [NUM_IRQ-1:0]              pend_q,
    output logic [NUM_IRQ-1:0]              tgt_q,
    output logic                            ctrl_q,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            tgt_q  <= '0;
            ctrl_q <= 1'b0;
            prio_q <= '0;
        end else begin
            if (en_we)   en_q   <= en_wd;
            pend_q <= (pend_we ? pend_wd : pend_q) | irq_in;
            if (tgt_we)  tgt_q  <= tgt_wd;
            if (ctrl_we) ctrl_q <= ctrl_wd;
            if (prio_we) prio_q <= prio_wd;
        end
    end

    AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(tgt_we) |-> (tgt_q == $past(tgt_q))); // R3
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(ctrl_we) |-> (ctrl_q == $past(ctrl_q))); // R9
    AST_IRQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n) (($past(irq_in) & ~pend_q) == '0)); // R11

endmodule

// File: rtl/irq_sec_select.sv
module irq_sec_select
    import irq_sec_pkg::*;
#(
    parameter int unsigned NUM_IRQ  = DEF_NUM_IRQ,
    parameter int unsigned PRIO_W   = DEF_PRIO_W,
    parameter bit          REMAP_EN = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_IRQ-1:0]              en_q,
    input  logic [NUM_IRQ-1:0]              pend_q,
    input  logic [NUM_IRQ-1:0]              tgt_q,
    input  logic                            ctrl_q,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_q,
    input  logic [PRIO_W:0]                 cur_prio,
    output logic                            sel_valid,
    output logic [$clog2(NUM_IRQ)-1:0]      sel_irq,
    output logic                            sel_target,
    output logic [PRIO_W-1:0]               sel_prio,
    output logic                            sel_preempt
);

    localparam int unsigned IDX_W = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0][PRIO_W-1:0] eff;
    logic [NUM_IRQ-1:0]             active;

    assign active = en_q & pend_q;

    for (genvar i = 0; i < int'(NUM_IRQ); i++) begin : g_eff
        if (REMAP_EN) begin : g_remap
            assign eff[i] = (ctrl_q && tgt_q[i]) ? {1'b1, prio_q[i][PRIO_W-1:1]} : prio_q[i];
        end else begin : g_plain
            assign eff[i] = prio_q[i];
        end
    end

    always_comb begin
        sel_valid  = 1'b0;
        sel_irq    = '0;
        sel_prio   = '0;
        for (int i = 0; i < int'(NUM_IRQ); i++) begin
            if (active[i] && (!sel_valid || eff[i] < sel_prio)) begin
                sel_valid = 1'b1;
                sel_irq   = IDX_W'(i);
                sel_prio  = eff[i];
            end
        end
        sel_target  = sel_valid && tgt_q[sel_irq];
        sel_preempt = sel_valid && ({1'b0, sel_prio} < cur_prio);
    end

    AST_WIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) sel_valid |-> (en_q[sel_irq] && pend_q[sel_irq])); // R6
    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (active == '0) |-> !sel_valid); // R6
    AST_PREEMPT_WIN: assert property (@(posedge clk) disable iff (!rst_n) sel_preempt |-> sel_valid); // R7
    AST_NS_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n) (sel_valid && sel_target && ctrl_q) |-> sel_prio[PRIO_W-1]); // R8

endmodule

// File: rtl/irq_sec_ctrl.sv
module irq_sec_ctrl
    import irq_sec_pkg::*;
#(
    parameter int unsigned NUM_IRQ  = DEF_NUM_IRQ,
    parameter int unsigned PRIO_W   = DEF_PRIO_W,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter bit          REMAP_EN = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [NUM_IRQ-1:0]         req_wdata,
    input  logic                       req_secure,
    input  logic                       req_priv,
    output logic                       rsp_valid,
    output logic [NUM_IRQ-1:0]         rsp_rdata,
    output logic                       rsp_violation,
    input  logic [NUM_IRQ-1:0]         irq_in,
    input  logic [PRIO_W:0]            cur_prio,
    output logic                       sel_valid,
    output logic [$clog2(NUM_IRQ)-1:0] sel_irq,
    output logic                       sel_target,
    output logic [PRIO_W-1:0]          sel_prio,
    output logic                       sel_preempt
);

    logic [NUM_IRQ-1:0]             en_q, pend_q, tgt_q, en_wd, pend_wd, tgt_wd;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q, prio_wd;
    logic                           ctrl_q, ctrl_wd;
    logic                           en_we, pend_we, tgt_we, ctrl_we, prio_we;

    irq_sec_access #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_access (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_violation(rsp_violation),
        .en_q(en_q), .pend_q(pend_q), .tgt_q(tgt_q), .ctrl_q(ctrl_q), .prio_q(prio_q),
        .en_we(en_we), .en_wd(en_wd), .pend_we(pend_we), .pend_wd(pend_wd),
        .tgt_we(tgt_we), .tgt_wd(tgt_wd), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .prio_we(prio_we), .prio_wd(prio_wd)
    );

    irq_sec_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .en_we(en_we), .en_wd(en_wd), .pend_we(pend_we), .pend_wd(pend_wd),
        .tgt_we(tgt_we), .tgt_wd(tgt_wd), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .prio_we(prio_we), .prio_wd(prio_wd),
        .en_q(en_q), .pend_q(pend_q), .tgt_q(tgt_q), .ctrl_q(ctrl_q), .prio_q(prio_q)
    );

    irq_sec_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .REMAP_EN(REMAP_EN)) u_select (
        .clk(clk), .rst_n(rst_n),
        .en_q(en_q), .pend_q(pend_q), .tgt_q(tgt_q), .ctrl_q(ctrl_q), .prio_q(prio_q),
        .cur_prio(cur_prio),
        .sel_valid(sel_valid), .sel_irq(sel_irq), .sel_target(sel_target),
        .sel_prio(sel_prio), .sel_preempt(sel_preempt)
    );

endmodule

// File: tb/irq_sec_ctrl_bench.sv
module irq_sec_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] irq_in = '0;
    logic [3:0]  cur_prio = 4'd8;
    logic        req_ready, rsp_valid, rsp_violation;
    logic [15:0] rsp_rdata;
    logic        sel_valid, sel_target, sel_preempt;
    logic [3:0]  sel_irq;
    logic [2:0]  sel_prio;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] exp_data_q[$];
    logic        exp_viol_q[$];
    logic        exp_isrd_q[$];
    string       exp_tag_q[$];

    always #10 clk = ~clk;

    irq_sec_ctrl u_irq_sec_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_violation(rsp_violation),
        .irq_in(irq_in), .cur_prio(cur_prio),
        .sel_valid(sel_valid), .sel_irq(sel_irq), .sel_target(sel_target),
        .sel_prio(sel_prio), .sel_preempt(sel_preempt)
    );

    // monitor: pops expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_tag_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected response: actual rsp_valid=1 expected 0");
            end else begin
                logic [15:0] ed;
                logic ev, er;
                string tg;
                ed = exp_data_q.pop_front();
                ev = exp_viol_q.pop_front();
                er = exp_isrd_q.pop_front();
                tg = exp_tag_q.pop_front();
                checks++;
                if (rsp_violation !== ev) begin
                    errors++;
                    $display("FAIL %s violation: actual %0b expected %0b", tg, rsp_violation, ev);
                end
                if (er) begin
                    checks++;
                    if (rsp_rdata !== ed) begin
                        errors++;
                        $display("FAIL %s rdata: actual %h expected %h", tg, rsp_rdata, ed);
                    end
                end
            end
        end
    end

    // driver: pushes the expected item, then performs one access
    task automatic access(input logic wr, input logic [3:0] addr, input logic [15:0] data,
                          input logic sec, input logic priv,
                          input logic [15:0] exp_rd, input logic exp_v, input string tag);
        exp_data_q.push_back(exp_rd);
        exp_viol_q.push_back(exp_v);
        exp_isrd_q.push_back(!wr);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        if (!req_ready) begin
            checks++; errors++;
            $display("FAIL R10 %s ready: actual 0 expected 1", tag);
        end
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
        req_secure = sec; req_priv = priv;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_sel(input logic v, input logic [3:0] idx, input logic tgt,
                             input logic [2:0] pr, input logic pre, input string tag);
        @(negedge clk);
        checks++;
        if (sel_valid !== v || (v && (sel_irq !== idx || sel_target !== tgt || sel_prio !== pr))
            || sel_preempt !== pre) begin
            errors++;
            $display("FAIL %s sel: actual v=%0b irq=%0d tgt=%0b prio=%0d pre=%0b expected v=%0b irq=%0d tgt=%0b prio=%0d pre=%0b",
                     tag, sel_valid, sel_irq, sel_target, sel_prio, sel_preempt, v, idx, tgt, pr, pre);
        end
    endtask

    task automatic pulse_irq(input logic [15:0] lines);
        @(negedge clk);
        irq_in = lines;
        @(negedge clk);
        irq_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_sel(1'b0, 4'd0, 1'b0, 3'd0, 1'b0, "R1");
        access(0, 4'd0, 16'h0, 1, 1, 16'h0000, 0, "R1 enable");
        access(0, 4'd1, 16'h0, 1, 1, 16'h0000, 0, "R1 pending");
        access(0, 4'd2, 16'h0, 1, 1, 16'h0000, 0, "R1 target");
        access(0, 4'd3, 16'h0, 1, 1, 16'h0000, 0, "R1 ctrl");
        access(0, 4'd4, 16'h0, 1, 1, 16'h0000, 0, "R1 prio");
        // R2 / R3 target programming
        access(1, 4'd2, 16'hFF00, 1, 1, 16'h0, 0, "R3 spriv write");
        access(0, 4'd2, 16'h0, 1, 1, 16'hFF00, 0, "R2 target readback");
        access(1, 4'd2, 16'h00FF, 0, 1, 16'h0, 1, "R3 ns write");
        access(1, 4'd2, 16'h00FF, 1, 0, 16'h0, 1, "R3 s unpriv write");
        access(0, 4'd2, 16'h0, 1, 1, 16'hFF00, 0, "R3 target unchanged");
        // R5 / R9 hidden state
        access(0, 4'd2, 16'h0, 0, 1, 16'h0000, 0, "R5 ns target read");
        access(1, 4'd3, 16'h0001, 0, 1, 16'h0, 1, "R9 ns ctrl write");
        access(0, 4'd3, 16'h0, 1, 1, 16'h0000, 0, "R9 ctrl unchanged");
        // R4 enable filtering
        access(1, 4'd0, 16'hFFFF, 0, 1, 16'h0, 1, "R4 ns enable all");
        access(0, 4'd0, 16'h0, 1, 1, 16'hFF00, 0, "R4 enable after ns");
        access(1, 4'd0, 16'hF000, 0, 0, 16'h0, 0, "R4 ns enable own only");
        access(1, 4'd0, 16'hF00F, 1, 0, 16'h0, 0, "R4 secure enable");
        access(0, 4'd0, 16'h0, 0, 1, 16'hF000, 0, "R5 ns enable read");
        access(0, 4'd0, 16'h0, 1, 1, 16'hF00F, 0, "R4 enable readback");
        // R4 / R5 priorities
        access(1, 4'd4, 16'h0005, 1, 1, 16'h0, 0, "R4 secure prio");
        access(1, 4'd7, 16'h6543, 0, 1, 16'h0, 0, "R4 ns prio own");
        access(1, 4'd4, 16'h0001, 0, 1, 16'h0, 1, "R4 ns prio secure irq");
        access(0, 4'd4, 16'h0, 1, 1, 16'h0005, 0, "R4 prio kept");
        access(0, 4'd4, 16'h0, 0, 1, 16'h0000, 0, "R5 ns prio read");
        access(0, 4'd7, 16'h0, 0, 1, 16'h6543, 0, "R5 ns prio own read");
        check_sel(1'b0, 4'd0, 1'b0, 3'd0, 1'b0, "R6 none pending");
        // R11 / R6 / R7 selection
        pulse_irq(16'h1000);
        check_sel(1'b1, 4'd12, 1'b1, 3'd3, 1'b1, "R11 R2 R7 irq12");
        cur_prio = 4'd3;
        check_sel(1'b1, 4'd12, 1'b1, 3'd3, 1'b0, "R7 equal no preempt");
        cur_prio = 4'd4;
        check_sel(1'b1, 4'd12, 1'b1, 3'd3, 1'b1, "R7 lower preempts");
        cur_prio = 4'd8;
        pulse_irq(16'h0020);
        access(0, 4'd1, 16'h0, 1, 1, 16'h1020, 0, "R11 disabled pend");
        check_sel(1'b1, 4'd12, 1'b1, 3'd3, 1'b1, "R6 disabled ignored");
        access(1, 4'd1, 16'h1021, 1, 1, 16'h0, 0, "R4 secure pend");
        check_sel(1'b1, 4'd12, 1'b1, 3'd3, 1'b1, "R6 urgency wins");
        // R8 remap and tie
        access(1, 4'd3, 16'h0001, 1, 1, 16'h0, 0, "R9 spriv ctrl");
        access(0, 4'd3, 16'h0, 1, 1, 16'h0001, 0, "R9 ctrl readback");
        check_sel(1'b1, 4'd0, 1'b0, 3'd5, 1'b1, "R8 R6 remap tie");
        access(1, 4'd3, 16'h0000, 1, 0, 16'h0, 1, "R9 s unpriv ctrl");
        check_sel(1'b1, 4'd0, 1'b0, 3'd5, 1'b1, "R9 remap kept");
        // R4 partial pending clear
        access(1, 4'd1, 16'h0000, 0, 1, 16'h0, 1, "R4 ns pend clear");
        access(0, 4'd1, 16'h0, 1, 1, 16'h0021, 0, "R4 pend survivors");
        check_sel(1'b1, 4'd0, 1'b0, 3'd5, 1'b1, "R6 secure remains");
        access(1, 4'd1, 16'h0000, 1, 1, 16'h0, 0, "R4 secure pend clear");
        check_sel(1'b0, 4'd0, 1'b0, 3'd0, 1'b0, "R6 none after clear");
        // R6 tie by number without remap
        access(1, 4'd3, 16'h0000, 1, 1, 16'h0, 0, "R9 ctrl off");
        access(1, 4'd7, 16'h6443, 1, 1, 16'h0, 0, "R4 secure writes ns prio");
        access(1, 4'd1, 16'h6000, 1, 1, 16'h0, 0, "R4 pend pair");
        cur_prio = 4'd4;
        check_sel(1'b1, 4'd13, 1'b1, 3'd4, 1'b0, "R6 tie lower number");
        repeat (2) @(negedge clk);
        checks++;
        if (exp_tag_q.size() != 0) begin
            errors++;
            $display("FAIL R10 missing responses: actual %0d pending expected 0", exp_tag_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule